// File: doc/BRIEF.md
# SD Host Interrupt Status Block

This block keeps the event and error flags of an SD host controller and turns them into one interrupt line. There are two 32-bit status words: an event word (response done, access done, card present) and an error/state word (timeouts, protocol errors, illegal access, buffer-ready flags, command busy, divider ready). Each status word has its own 32-bit mask word. The command and data engines raise single-cycle event pulses, which set sticky flags. Software clears a flag by writing a zero to its bit position. Writing a one leaves the flag as it is.

The two buffer-ready flags are set on edges, not on levels. The buffer-side engine drives a level that is high while a complete block is waiting to be drained (read direction) or while a block slot is free to fill (write direction). The flag is set once on each rising edge of that level, so a flag cleared by software stays clear while the same block is being moved. Command busy, divider ready and card present are live read-only bits: the card level passes through a synchronizer first. When software attempts a command write while the command path is busy, the block drops the write and sets an illegal-access flag.

Top module: `sdirq_status_top`

## Requirements
- R1: After reset every sticky flag is 0, both mask words read 0xFFFFFFFF and `irq` is 0.
- R2: A one-cycle pulse on an event input sets its flag at the next clock edge, and the flag stays set until it is cleared. Event word: response done is bit 0 and access done is bit 2. Error word: index error is bit 0, CRC error bit 1, end-bit error bit 2, data timeout bit 3, illegal read bit 4, illegal write bit 5, response timeout bit 6 and illegal address/command bit 7.
- R3: A write of a status word clears every sticky flag whose data bit is 0 and leaves unchanged every flag whose data bit is 1.
- R4: When a set event and a zero-write to the same flag fall in the same cycle, the flag ends up set.
- R5: The buffer-read-ready flag (error bit 8) is set only on a rising edge of `blk_rd_full`. After it is cleared it stays 0 while the level is still high, and the next rising edge sets it again. The buffer-write-ready flag (error bit 9) follows the same rule on `blk_wr_empty`.
- R6: The response timeout flag (bit 6) and the data timeout flag (bit 3) are independent: raising one leaves the other at 0.
- R7: While `cmd_busy` is high, a `cmd_wr` request holds `cmd_go` low and sets error bit 7 at the next edge. While `cmd_busy` is low, `cmd_go` follows `cmd_wr` and no flag is set.
- R8: Event bit 4 shows `card_in` after a two-stage synchronizer, so it changes after the second clock edge. Error bit 14 shows `cmd_busy` live and error bit 13 shows `clkdiv_rdy` live. Writes have no effect on any of these three bits.
- R9: `irq` is 1 exactly when some status bit, sticky or live, is 1 while its mask bit is 0. Mask writes take effect at the next edge.
- R10: `wr_sel` and `rd_sel` pick the register: 0 selects the event word, 1 the event mask, 2 the error word, 3 the error mask. `rd_data` is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selected for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register selected for the read |
| rd_data | output | 32 | Read data |
| ev_resp_done | input | 1 | Response received pulse |
| ev_access_done | input | 1 | Access complete pulse |
| ev_resp_tmo | input | 1 | Response timeout pulse |
| ev_data_tmo | input | 1 | Data timeout pulse |
| ev_end_err | input | 1 | End-bit error pulse |
| ev_crc_err | input | 1 | CRC error pulse |
| ev_idx_err | input | 1 | Index error pulse |
| ev_ill_rd | input | 1 | Illegal read pulse |
| ev_ill_wr | input | 1 | Illegal write pulse |
| blk_rd_full | input | 1 | Level: full block waiting to be read |
| blk_wr_empty | input | 1 | Level: block space free for writing |
| card_in | input | 1 | Asynchronous card-present level |
| cmd_busy | input | 1 | Command path busy level |
| clkdiv_rdy | input | 1 | Clock divider ready level |
| cmd_wr | input | 1 | Software command write request |
| cmd_go | output | 1 | Command write accepted |
| irq | output | 1 | Combined interrupt |

## Verification
The sticky flags are driven with single pulses, with groups of simultaneous pulses, and with pulses that arrive in the same cycle as a zero-write. These cases separate write-zero-clear from write-one-clear and show that a set has priority over a clear. The buffer levels are held high across a clear, then dropped and raised again, which tells an edge-set flag from a level-following one. Command writes are issued with busy high and with busy low, which shows blocking apart from passing. The interrupt is observed while the mask is opened and closed one bit at a time over both sticky and live bits.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;
   localparam int unsigned WORD_W = 32;

   typedef enum logic [1:0] {
      SEL_EVT      = 2'd0,
      SEL_EVT_MASK = 2'd1,
      SEL_ERR      = 2'd2,
      SEL_ERR_MASK = 2'd3
   } reg_sel_e;

   // event word
   localparam int unsigned EB_RESP_DONE   = 0;
   localparam int unsigned EB_ACCESS_DONE = 2;
   localparam int unsigned EB_CARD        = 4;

   // error word
   localparam int unsigned XB_IDX      = 0;
   localparam int unsigned XB_CRC      = 1;
   localparam int unsigned XB_END      = 2;
   localparam int unsigned XB_DATA_TMO = 3;
   localparam int unsigned XB_ILL_RD   = 4;
   localparam int unsigned XB_ILL_WR   = 5;
   localparam int unsigned XB_RESP_TMO = 6;
   localparam int unsigned XB_ILL_CMD  = 7;
   localparam int unsigned XB_BUF_RD   = 8;
   localparam int unsigned XB_BUF_WR   = 9;
   localparam int unsigned XB_CLKDIV   = 13;
   localparam int unsigned XB_BUSY     = 14;
endpackage

// File: rtl/sdirq_sync.sv
module sdirq_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] q_sync
);
   logic [W-1:0] chain_q [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("sdirq_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      end else begin
         chain_q[0] <= d_async;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sdirq_rise.sv
module sdirq_rise #(
   parameter int unsigned W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] rise
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
endmodule

// File: rtl/sdirq_flag_bank.sv
module sdirq_flag_bank #(
   parameter int unsigned W      = 32,
   parameter logic [W-1:0] STICKY = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_v,
   input  logic         clr_we,
   input  logic [W-1:0] clr_data,
   output logic [W-1:0] flags
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (STICKY[i]) begin : g_flop
         logic f_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     f_q <= 1'b0;
            else if (set_v[i])              f_q <= 1'b1;
            else if (clr_we && !clr_data[i]) f_q <= 1'b0;
         end
         assign flags[i] = f_q;
      end else begin : g_none
         assign flags[i] = 1'b0;
      end
   end
endmodule

// File: rtl/sdirq_status_top.sv
module sdirq_status_top
   import sdirq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [31:0] MASK_RESET  = 32'hFFFF_FFFF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  wr_sel,
   input  logic [31:0] wr_data,
   input  logic [1:0]  rd_sel,
   output logic [31:0] rd_data,
   input  logic        ev_resp_done,
   input  logic        ev_access_done,
   input  logic        ev_resp_tmo,
   input  logic        ev_data_tmo,
   input  logic        ev_end_err,
   input  logic        ev_crc_err,
   input  logic        ev_idx_err,
   input  logic        ev_ill_rd,
   input  logic        ev_ill_wr,
   input  logic        blk_rd_full,
   input  logic        blk_wr_empty,
   input  logic        card_in,
   input  logic        cmd_busy,
   input  logic        clkdiv_rdy,
   input  logic        cmd_wr,
   output logic        cmd_go,
   output logic        irq
);
   localparam int unsigned W = WORD_W;
   localparam logic [W-1:0] EVT_STICKY = (W'(1) << EB_RESP_DONE) | (W'(1) << EB_ACCESS_DONE);
   localparam logic [W-1:0] ERR_STICKY = (W'(1) << (XB_BUF_WR + 1)) - W'(1);

   if (W != 32) begin : g_bad_width
      $error("sdirq_status_top: word width must be 32");
   end

   logic [W-1:0] evt_set, err_set;
   logic [W-1:0] evt_flags, err_flags;
   logic [W-1:0] evt_mask_q, err_mask_q;
   logic [W-1:0] evt_view, err_view;
   logic [1:0]   buf_rise;
   logic         card_s;
   logic         cmd_blocked;

   sdirq_sync #(.STAGES(SYNC_STAGES), .W(1)) u_card_sync (
      .clk(clk), .rst_n(rst_n), .d_async(card_in), .q_sync(card_s)
   );

   sdirq_rise #(.W(2)) u_buf_edge (
      .clk(clk), .rst_n(rst_n),
      .lvl({blk_wr_empty, blk_rd_full}), .rise(buf_rise)
   );

   assign cmd_blocked = cmd_wr & cmd_busy;
   assign cmd_go      = cmd_wr & ~cmd_busy;

   always_comb begin
      evt_set = '0;
      evt_set[EB_RESP_DONE]   = ev_resp_done;
      evt_set[EB_ACCESS_DONE] = ev_access_done;
      err_set = '0;
      err_set[XB_IDX]      = ev_idx_err;
      err_set[XB_CRC]      = ev_crc_err;
      err_set[XB_END]      = ev_end_err;
      err_set[XB_DATA_TMO] = ev_data_tmo;
      err_set[XB_ILL_RD]   = ev_ill_rd;
      err_set[XB_ILL_WR]   = ev_ill_wr;
      err_set[XB_RESP_TMO] = ev_resp_tmo;
      err_set[XB_ILL_CMD]  = cmd_blocked;
      err_set[XB_BUF_RD]   = buf_rise[0];
      err_set[XB_BUF_WR]   = buf_rise[1];
   end

   sdirq_flag_bank #(.W(W), .STICKY(EVT_STICKY)) u_evt_bank (
      .clk(clk), .rst_n(rst_n), .set_v(evt_set),
      .clr_we(wr_en && (wr_sel == SEL_EVT)), .clr_data(wr_data),
      .flags(evt_flags)
   );

   sdirq_flag_bank #(.W(W), .STICKY(ERR_STICKY)) u_err_bank (
      .clk(clk), .rst_n(rst_n), .set_v(err_set),
      .clr_we(wr_en && (wr_sel == SEL_ERR)), .clr_data(wr_data),
      .flags(err_flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_mask_q <= MASK_RESET;
         err_mask_q <= MASK_RESET;
      end else if (wr_en) begin
         if (wr_sel == SEL_EVT_MASK) evt_mask_q <= wr_data;
         if (wr_sel == SEL_ERR_MASK) err_mask_q <= wr_data;
      end
   end

   always_comb begin
      evt_view = evt_flags;
      evt_view[EB_CARD] = card_s;
      err_view = err_flags;
      err_view[XB_CLKDIV] = clkdiv_rdy;
      err_view[XB_BUSY]   = cmd_busy;
   end

   always_comb begin
      unique case (reg_sel_e'(rd_sel))
         SEL_EVT:      rd_data = evt_view;
         SEL_EVT_MASK: rd_data = evt_mask_q;
         SEL_ERR:      rd_data = err_view;
         SEL_ERR_MASK: rd_data = err_mask_q;
         default:      rd_data = '0;
      endcase
   end

   assign irq = |(evt_view & ~evt_mask_q) | |(err_view & ~err_mask_q);
endmodule

// File: rtl/sdirq_status_chk.sv
module sdirq_status_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [1:0]  wr_sel,
   input logic [31:0] wr_data,
   input logic        ev_resp_tmo,
   input logic        ev_data_tmo,
   input logic        ev_crc_err,
   input logic        blk_rd_full,
   input logic        cmd_wr,
   input logic        cmd_busy,
   input logic        cmd_go,
   input logic        irq,
   input logic [31:0] err_flags,
   input logic [31:0] err_mask
);
   assert_resp_tmo_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_resp_tmo |=> err_flags[6]);

   assert_zero_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd2 && !wr_data[3] && !ev_data_tmo) |=> !err_flags[3]);

   assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd2 && !wr_data[1] && ev_crc_err) |=> err_flags[1]);

   assert_buf_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(blk_rd_full) |=> err_flags[8]);

   assert_tmo_split_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_resp_tmo && !ev_data_tmo && !err_flags[3]) |=> !err_flags[3]);

   assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_busy) |-> !cmd_go);

   assert_busy_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_busy) |=> err_flags[7]);

   assert_irq_on_unmasked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((err_flags & ~err_mask) != 32'd0) |-> irq);
endmodule

bind sdirq_status_top sdirq_status_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
   .ev_resp_tmo(ev_resp_tmo), .ev_data_tmo(ev_data_tmo), .ev_crc_err(ev_crc_err),
   .blk_rd_full(blk_rd_full), .cmd_wr(cmd_wr), .cmd_busy(cmd_busy),
   .cmd_go(cmd_go), .irq(irq), .err_flags(err_flags), .err_mask(err_mask_q)
);

// File: tb/tb_sdirq_status_top.sv
`timescale 1ns/1ps
module tb_sdirq_status_top;
   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 0; logic [1:0] wr_sel = 0; logic [31:0] wr_data = 0;
   logic [1:0] rd_sel = 0; logic [31:0] rd_data;
   logic ev_resp_done = 0, ev_access_done = 0, ev_resp_tmo = 0, ev_data_tmo = 0;
   logic ev_end_err = 0, ev_crc_err = 0, ev_idx_err = 0, ev_ill_rd = 0, ev_ill_wr = 0;
   logic blk_rd_full = 0, blk_wr_empty = 0, card_in = 0, cmd_busy = 0, clkdiv_rdy = 0;
   logic cmd_wr = 0, cmd_go, irq;
   int n_tests = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   sdirq_status_top dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .ev_resp_done(ev_resp_done),
      .ev_access_done(ev_access_done), .ev_resp_tmo(ev_resp_tmo), .ev_data_tmo(ev_data_tmo),
      .ev_end_err(ev_end_err), .ev_crc_err(ev_crc_err), .ev_idx_err(ev_idx_err),
      .ev_ill_rd(ev_ill_rd), .ev_ill_wr(ev_ill_wr), .blk_rd_full(blk_rd_full),
      .blk_wr_empty(blk_wr_empty), .card_in(card_in), .cmd_busy(cmd_busy),
      .clkdiv_rdy(clkdiv_rdy), .cmd_wr(cmd_wr), .cmd_go(cmd_go), .irq(irq)
   );

   task automatic step();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] sel, logic [31:0] d);
      wr_en = 1; wr_sel = sel; wr_data = d;
      step();
      wr_en = 0;
   endtask

   task automatic rd_chk(string req, logic [1:0] sel, logic [31:0] exp);
      rd_sel = sel; #1;
      check(req, rd_data, exp);
   endtask

   task automatic t_reset();
      rd_chk("R1 evt", 2'd0, 32'h0);
      rd_chk("R1 evt mask", 2'd1, 32'hFFFF_FFFF);
      rd_chk("R1 err", 2'd2, 32'h0);
      rd_chk("R1 err mask", 2'd3, 32'hFFFF_FFFF);
      check("R1 irq", {31'd0, irq}, 32'd0);
   endtask

   task automatic t_set_clear();
      ev_resp_done = 1; step(); ev_resp_done = 0;
      rd_chk("R2 resp done", 2'd0, 32'h1);
      step();
      rd_chk("R2 stays", 2'd0, 32'h1);
      ev_access_done = 1; step(); ev_access_done = 0;
      rd_chk("R2 access done", 2'd0, 32'h5);
      wr(2'd0, 32'hFFFF_FFFE);
      rd_chk("R3 zero clears one bit", 2'd0, 32'h4);
      wr(2'd0, 32'h0);
      rd_chk("R3 full clear", 2'd0, 32'h0);
   endtask

   task automatic t_errors();
      ev_resp_tmo = 1; step(); ev_resp_tmo = 0;
      rd_chk("R6 resp tmo only", 2'd2, 32'h40);
      wr(2'd2, 32'h0);
      ev_data_tmo = 1; step(); ev_data_tmo = 0;
      rd_chk("R6 data tmo only", 2'd2, 32'h08);
      ev_crc_err = 1; ev_end_err = 1; ev_idx_err = 1; ev_ill_rd = 1; ev_ill_wr = 1;
      step();
      ev_crc_err = 0; ev_end_err = 0; ev_idx_err = 0; ev_ill_rd = 0; ev_ill_wr = 0;
      rd_chk("R2 error group", 2'd2, 32'h3F);
      wr(2'd2, 32'hFFFF_FFF7);
      rd_chk("R3 one leaves others", 2'd2, 32'h37);
      wr(2'd2, 32'h0);
      rd_chk("R3 err clear", 2'd2, 32'h0);
   endtask

   task automatic t_collide();
      ev_crc_err = 1;
      wr(2'd2, 32'h0);
      ev_crc_err = 0;
      rd_chk("R4 set beats clear", 2'd2, 32'h02);
      wr(2'd2, 32'h0);
   endtask

   task automatic t_buf();
      blk_rd_full = 1; step();
      rd_chk("R5 rd edge sets", 2'd2, 32'h100);
      wr(2'd2, 32'h0);
      step(); step();
      rd_chk("R5 level no reset", 2'd2, 32'h0);
      blk_rd_full = 0; step();
      rd_chk("R5 fall nothing", 2'd2, 32'h0);
      blk_rd_full = 1; step();
      rd_chk("R5 next edge", 2'd2, 32'h100);
      blk_rd_full = 0;
      wr(2'd2, 32'h0);
      blk_wr_empty = 1; step();
      rd_chk("R5 wr edge sets", 2'd2, 32'h200);
      wr(2'd2, 32'h0);
      step();
      rd_chk("R5 wr level no reset", 2'd2, 32'h0);
      blk_wr_empty = 0; step();
   endtask

   task automatic t_busy();
      cmd_busy = 1;
      rd_chk("R8 busy live", 2'd2, 32'h4000);
      wr(2'd2, 32'h0);
      rd_chk("R8 busy not writable", 2'd2, 32'h4000);
      cmd_wr = 1; #1;
      check("R7 blocked go", {31'd0, cmd_go}, 32'd0);
      step(); cmd_wr = 0;
      rd_chk("R7 illegal flag", 2'd2, 32'h4080);
      cmd_busy = 0;
      wr(2'd2, 32'h0);
      cmd_wr = 1; #1;
      check("R7 accepted go", {31'd0, cmd_go}, 32'd1);
      step(); cmd_wr = 0;
      rd_chk("R7 no flag", 2'd2, 32'h0);
      clkdiv_rdy = 1;
      rd_chk("R8 divider live", 2'd2, 32'h2000);
      clkdiv_rdy = 0;
   endtask

   task automatic t_card();
      card_in = 1; step();
      rd_chk("R8 card one edge", 2'd0, 32'h0);
      step();
      rd_chk("R8 card two edges", 2'd0, 32'h10);
      wr(2'd0, 32'h0);
      rd_chk("R8 card not writable", 2'd0, 32'h10);
   endtask

   task automatic t_irq();
      ev_crc_err = 1; step(); ev_crc_err = 0;
      check("R9 masked", {31'd0, irq}, 32'd0);
      wr(2'd3, 32'hFFFF_FFFD);
      rd_chk("R10 err mask read", 2'd3, 32'hFFFF_FFFD);
      check("R9 unmasked crc", {31'd0, irq}, 32'd1);
      wr(2'd2, 32'h0);
      check("R9 cleared flag", {31'd0, irq}, 32'd0);
      wr(2'd3, 32'hFFFF_FFFF);
      wr(2'd1, 32'hFFFF_FFEF);
      check("R9 live card unmasked", {31'd0, irq}, 32'd1);
      wr(2'd1, 32'hFFFF_FFFF);
      check("R9 remasked", {31'd0, irq}, 32'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      step(); step();
      rst_n = 1;
      step();
      t_reset();
      t_set_clear();
      t_errors();
      t_collide();
      t_buf();
      t_busy();
      t_card();
      t_irq();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule